// File: doc/BRIEF.md
# Idle-Low Serial Frame Receiver

This block receives asynchronous serial frames whose line rests at logic 0 between frames and signals a frame start by driving the line to logic 1. Bit timing comes from a periodic single-cycle tick strobe, and one bit lasts a fixed number of ticks. After a rising start edge the receiver waits half a bit and confirms that the start level is still present. It then samples each data bit near its centre, least significant bit first, and shifts it into a register. When the frame ends it copies the assembled byte to a parallel output.

The final (stop) position of the frame decides the outcome. A stop level of 0 raises a ready flag for exactly one bit time. A stop level of 1 raises an error flag, and the flag stays up until the line falls back to 0. A test-select input switches the receive source from the external pin, which passes through a synchronizer first, to the local transmitter's line, so that one unit can check its own send path.

Top module: `idle_low_frame_rx`

## Requirements
- R1: After reset the byte output is 0 and both the ready and error outputs are 0.
- R2: The selected line rests at 0. A 0-to-1 transition on it starts frame reception, and no output changes while the line stays at 0.
- R3: Eight ticks after the start edge the line is sampled again. If it reads 0 the frame is dropped, and the byte, ready and error outputs all keep their values.
- R4: Each bit occupies 16 ticks. The eight data bits follow the start bit, bit 0 first and bit 7 last, and the byte output bit i carries data bit i.
- R5: A stop level of 0 sets ready high for 16 ticks, after which ready returns to 0.
- R6: A stop level of 1 sets error high, and error stays high for as long as the selected line stays at 1. It clears once the line reads 0.
- R7: The byte output keeps the last received byte while a frame is in progress. It takes the new byte when the stop bit is sampled, whatever the stop level.
- R8: With test_sel = 1 the receiver decodes loc_line and ignores ext_line. With test_sel = 0 it decodes ext_line and ignores loc_line.
- R9: While error is held no new frame starts. After the line returns to 0, the next 0-to-1 edge starts a normal frame.
- R10: Ready and error are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Single-cycle timing strobe, 16 per bit |
| ext_line | input | 1 | External serial input, asynchronous |
| loc_line | input | 1 | Local transmitter serial line, synchronous to clk |
| test_sel | input | 1 | 1 selects loc_line (loopback), 0 selects ext_line |
| rx_byte | output | 8 | Last received byte |
| rx_ready | output | 1 | Good-frame flag, high for one bit time |
| rx_error | output | 1 | Bad-stop flag, held while the line stays at 1 |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, eight data bits and a two-stage synchronizer. It strobes the tick every four clocks, so one frame takes about 640 clocks. That short frame leaves room for many random bytes together with directed cases in one run: a start pulse that ends before the half-bit check, a held and then released stop error, and frames sent on the source that is not selected. Every sample point falls inside a bit window with several ticks to spare, so the checks hold whether or not the synchronizer delay applies.

// File: rtl/rxinv_pkg.sv
package rxinv_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_STOP  = 3'd3,
    S_ERR   = 3'd4
  } rx_state_e;

  // tick count (zero based) at which the start level is confirmed
  function automatic int unsigned mid_limit(int unsigned tpb);
    return (tpb / 2) - 1;
  endfunction

  // tick count (zero based) that closes one bit window
  function automatic int unsigned full_limit(int unsigned tpb);
    return tpb - 1;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import rxinv_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic mid_hit,
  output logic full_hit
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] MID  = CW'(mid_limit(TICKS_PER_BIT));
  localparam logic [CW-1:0] FULL = CW'(full_limit(TICKS_PER_BIT));

  logic [CW-1:0] cnt;

  assign mid_hit  = tick && (cnt == MID);
  assign full_hit = tick && (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (full_hit) cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx_shift_reg.sv
module rx_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] par_out
);
  // first bit in ends at bit 0 after WIDTH shifts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        par_out <= '0;
    else if (shift_en) par_out <= {bit_in, par_out[WIDTH-1:1]};
  end
endmodule

// File: rtl/rx_ready_pulse.sv
module rx_ready_pulse #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fire,
  output logic ready
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      cnt   <= '0;
    end else if (fire) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (ready && tick) begin
      if (cnt == LAST) ready <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/idle_low_frame_rx.sv
module idle_low_frame_rx
  import rxinv_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 ext_line,
  input  logic                 loc_line,
  input  logic                 test_sel,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_ready,
  output logic                 rx_error
);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  rx_state_e state;
  logic [BW-1:0] bit_idx;
  logic ext_s, line_now, line_prev, rise;
  logic mid_hit, full_hit, timer_clear;
  logic start_ok, start_abort, bit_take, stop_take, stop_good, stop_bad;
  logic err_release;
  logic [DATA_BITS-1:0] shift_q;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_line), .q(ext_s)
  );

  // loopback source is already in this clock domain
  assign line_now = test_sel ? loc_line : ext_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) line_prev <= 1'b0;
    else        line_prev <= line_now;

  assign rise        = line_now && !line_prev;
  assign start_ok    = (state == S_START) && mid_hit && line_now;
  assign start_abort = (state == S_START) && mid_hit && !line_now;
  assign bit_take    = (state == S_DATA) && full_hit;
  assign stop_take   = (state == S_STOP) && full_hit;
  assign stop_good   = stop_take && !line_now;
  assign stop_bad    = stop_take && line_now;
  assign err_release = (state == S_ERR) && !line_now;
  assign timer_clear = (state == S_IDLE) || (state == S_ERR) || start_ok;

  rx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(timer_clear),
    .mid_hit(mid_hit), .full_hit(full_hit)
  );

  rx_shift_reg #(.WIDTH(DATA_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_take), .bit_in(line_now),
    .par_out(shift_q)
  );

  rx_ready_pulse #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_rdy (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fire(stop_good), .ready(rx_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bit_idx <= '0;
    end else begin
      case (state)
        S_IDLE:  if (rise) state <= S_START;
        S_START: begin
          if (start_ok) begin
            state   <= S_DATA;
            bit_idx <= '0;
          end else if (start_abort) begin
            state <= S_IDLE;
          end
        end
        S_DATA: if (bit_take) begin
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == LAST_BIT) state <= S_STOP;
        end
        S_STOP: begin
          if (stop_good)     state <= S_IDLE;
          else if (stop_bad) state <= S_ERR;
        end
        S_ERR:   if (err_release) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         rx_byte <= '0;
    else if (stop_take) rx_byte <= shift_q;

  assign rx_error = (state == S_ERR);

  // R10
  rdy_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && rx_error));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_error && line_now) |=> rx_error);

  // R5
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(stop_good));

  // R3
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |=> (state == S_IDLE));

  // R7
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_take |=> $stable(rx_byte));

  // R9
  no_start_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERR) |=> (state != S_START));

endmodule

// File: tb/sim_idle_low_frame_rx.sv
module sim_idle_low_frame_rx;
  logic clk = 0, rst_n = 0, tick = 0;
  logic ext_line = 0, loc_line = 0, test_sel = 0;
  logic [7:0] rx_byte;
  logic rx_ready, rx_error;
  logic [1:0] div = 0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] last_byte = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    div  <= div + 1'b1;
    tick <= (div == 2'd3);
  end

  idle_low_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_line(ext_line),
    .loc_line(loc_line), .test_sel(test_sel), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .rx_error(rx_error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic drive(input bit on_loc, input logic v);
    if (on_loc) loc_line = v; else ext_line = v;
  endtask

  function automatic logic frame_bit(input logic [7:0] b, input logic stopv, input int k);
    if (k == 0) return 1'b1;
    if (k == 9) return stopv;
    return b[k-1];
  endfunction

  // R4 R7: send one frame; byte output must hold the old value mid-frame
  task automatic send_frame(input logic [7:0] b, input logic stopv, input bit on_loc);
    for (int k = 0; k < 10; k++) begin
      drive(on_loc, frame_bit(b, stopv, k));
      wait_ticks(16);
      if (k == 5) chk(rx_byte == last_byte, "R7 mid-frame hold", rx_byte, last_byte);
    end
  endtask

  // full receive with outcome checks, expected values from the stop level
  task automatic rx_and_check(input logic [7:0] b, input logic stopv, input bit on_loc);
    send_frame(b, stopv, on_loc);
    chk(rx_byte == b, "R4 byte value", rx_byte, b);
    last_byte = b;
    if (!stopv) begin
      chk(rx_ready == 1'b1, "R5 ready on good stop", rx_ready, 1);
      chk(rx_error == 1'b0, "R10 no error on good stop", rx_error, 0);
      wait_ticks(10);
      chk(rx_ready == 1'b0, "R5 ready ends after 16 ticks", rx_ready, 0);
    end else begin
      chk(rx_error == 1'b1, "R6 error on bad stop", rx_error, 1);
      chk(rx_ready == 1'b0, "R10 no ready on bad stop", rx_ready, 0);
      wait_ticks(20);
      chk(rx_error == 1'b1, "R6 error held while line high", rx_error, 1);
      drive(on_loc, 1'b0);
      wait_ticks(2);
      chk(rx_error == 1'b0, "R6 error clears on line low", rx_error, 0);
    end
    drive(on_loc, 1'b0);
    wait_ticks(4);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    chk(rx_byte == 8'h00, "R1 reset byte", rx_byte, 0);
    chk(rx_ready == 1'b0, "R1 reset ready", rx_ready, 0);
    chk(rx_error == 1'b0, "R1 reset error", rx_error, 0);
    rst_n = 1;
    wait_ticks(40);
    chk(rx_ready == 0 && rx_error == 0 && rx_byte == 0, "R2 idle line quiet",
        {rx_ready, rx_error}, 0);

    // directed corner values, good stop
    rx_and_check(8'h01, 1'b0, 1'b0);
    rx_and_check(8'h80, 1'b0, 1'b0);
    rx_and_check(8'h00, 1'b0, 1'b0);

    // R3: short start pulse dropped
    ext_line = 1; wait_ticks(4); ext_line = 0;
    wait_ticks(200);
    chk(rx_ready == 0 && rx_error == 0, "R3 glitch no flags", {rx_ready, rx_error}, 0);
    chk(rx_byte == last_byte, "R3 glitch byte kept", rx_byte, last_byte);

    // R6 R9: bad stop, then a normal frame after release
    rx_and_check(8'h3C, 1'b1, 1'b0);
    rx_and_check(8'hC3, 1'b0, 1'b0);

    // R8: loopback source, external line held high and ignored
    test_sel = 1;
    wait_ticks(2);
    ext_line = 1;
    rx_and_check(8'h5A, 1'b0, 1'b1);
    ext_line = 0;
    wait_ticks(4);
    test_sel = 0;
    wait_ticks(4);
    // R8: local line ignored when test_sel = 0
    send_frame(8'hA5, 1'b0, 1'b1);
    wait_ticks(2);
    chk(rx_byte == last_byte, "R8 local line ignored", rx_byte, last_byte);
    chk(rx_ready == 1'b0, "R8 no ready from local line", rx_ready, 0);
    wait_ticks(20);

    // random bytes and stop levels
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      logic s;
      b = 8'($urandom);
      s = ($urandom % 4) == 0;
      rx_and_check(b, s, ($urandom % 2) == 1 ? 1'b0 : 1'b0);
    end
    test_sel = 1;
    wait_ticks(2);
    for (int i = 0; i < 3; i++) rx_and_check(8'($urandom), 1'b0, 1'b1);
    test_sel = 0;
    wait_ticks(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule